// File: doc/BRIEF.md
# Quarter-Duty Multiplexed LCD Timing Generator

This block sequences a four-backplane, thirty-two-frontplane liquid-crystal panel that runs at quarter duty with third bias. It works from a clock enable derived from the panel oscillator. For every plane it emits a 2-bit drive level code: 00 is 0 V, 01 is one third, 10 is two thirds and 11 is full voltage. An analog stage outside the block turns these codes into voltages. The pattern to show comes in as a 128-bit word. During the slot of backplane `s`, frontplane `j` shows bit `s*32 + j` of that word.

Each backplane slot is 250 oscillator ticks long and is split into two halves of 125 ticks. A frame is four slots, backplanes 1 to 4 in order, so it lasts 1000 ticks. Several of these blocks can share one panel. The block set to master marks the start of every frame with a sync pulse. A block set to slave ignores that output and instead restarts its frame on a rising edge of the sync input. Each time the backplane levels move, a high-current strobe stays up for a few oscillator ticks so the drivers can charge the panel load quickly.

Top module: `lcdmux_timing`

## Requirements
- R1: Each backplane slot lasts 2*125 oscillator ticks. The slots run in the order plane 0, 1, 2, 3 and then wrap. A frame is therefore 1000 ticks, so with the tick high on every clock the master sync pulses come 1000 clocks apart.
- R2: The active backplane is coded 11 in the first half of its slot and 00 in the second half. Every inactive backplane is coded 01 in the first half and 10 in the second. Backplane `i` occupies bits [2i+1:2i] of `bp_lvl`.
- R3: A frontplane whose bit is 1 is coded 00 and then 11. A frontplane whose bit is 0 is coded 10 and then 01. Frontplane `j` occupies bits [2j+1:2j] of `fp_lvl`, and in slot `s` it takes bit `s*32+j` of `disp_word`.
- R4: The 32-bit block for a slot is captured from `disp_word` only when that slot begins. A change to `disp_word` in the middle of a slot has no effect on `fp_lvl` until the next slot boundary.
- R5: When `master_sel` is 1, `fsync_out` is high for exactly one clock in each frame. That clock is the first one in which the plane-0 active first-half codes are on the outputs. The first frame after reset has no pulse.
- R6: When `master_sel` is 0, `fsync_out` stays 0. A rising edge of `fsync_in` restarts the frame at the first half of plane 0 and recaptures block 0. When `master_sel` is 1, `fsync_in` is ignored.
- R7: `hc_strobe` rises in the same clock as any change of `bp_lvl`. It stays high until 4 oscillator ticks have been counted, then drops.
- R8: The timing advances only on clocks where `osc_tick` is 1. While `osc_tick` is held at 0, all level outputs hold their values.
- R9: A synchronous reset places the sequencer at the start of plane 0's slot. While reset is high the outputs read: plane 0 at 11, the other backplanes at 01, all frontplanes at 10, `fsync_out` at 0 and `hc_strobe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-clock enable per oscillator period |
| master_sel | input | 1 | 1 = master (drives sync), 0 = slave (follows sync) |
| fsync_in | input | 1 | Frame sync from a master, used in slave mode |
| disp_word | input | 128 | Latched segment pattern, 32 bits per backplane slot |
| fsync_out | output | 1 | Frame-start pulse in master mode |
| bp_lvl | output | 8 | Backplane level codes, 2 bits per plane |
| fp_lvl | output | 64 | Frontplane level codes, 2 bits per plane |
| hc_strobe | output | 1 | High-current window after backplane changes |

## Verification
Assertions check properties on every cycle. Exactly one backplane is active at a time. Every frontplane is always in the opposite half-phase from the backplanes. The strobe is raised on each backplane change and drops only on a tick. The slot index only steps forward. The counters stay frozen without a tick. A slave never pulses sync, and the master pulses only alongside the plane-0 codes. Other behaviour can only be shown by the bench's scenarios against an independent tick-position model: the exact 1000-tick frame length, the bit-to-plane mapping, pattern changes in mid-slot that stay hidden until the next boundary, the slave realigning to a sync edge, sync being ignored in master mode, and the four-tick length of each strobe window.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_GND       = 2'b00;
  localparam lvl_t LVL_ONE_THIRD = 2'b01;
  localparam lvl_t LVL_TWO_THIRD = 2'b10;
  localparam lvl_t LVL_FULL      = 2'b11;
endpackage

// File: rtl/lcdmux_seq.sv
// Slot / half / tick sequencer with slave realignment.
module lcdmux_seq #(
  parameter int NUM_BP     = 4,
  parameter int HALF_TICKS = 125,
  parameter int SLOT_W     = 2,
  parameter int CYC_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              master_sel,
  input  logic              fsync_in,
  output logic [SLOT_W-1:0] slot,
  output logic              half,
  output logic              slot_load,
  output logic [SLOT_W-1:0] load_slot,
  output logic              resync,
  output logic              frame_mark
);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(HALF_TICKS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_BP - 1);

  logic [CYC_W-1:0] cyc;
  logic             fs_prev;
  logic             slot_end;
  logic             frame_end;

  always_comb begin
    resync    = !master_sel && fsync_in && !fs_prev;
    slot_end  = tick && half && (cyc == CYC_LAST);
    frame_end = slot_end && (slot == SLOT_LAST);
    slot_load = rst || resync || slot_end;
    if (rst || resync || frame_end) load_slot = '0;
    else                            load_slot = slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc        <= '0;
      half       <= 1'b0;
      slot       <= '0;
      fs_prev    <= 1'b0;
      frame_mark <= 1'b0;
    end else begin
      fs_prev    <= fsync_in;
      frame_mark <= frame_end && !resync;
      if (resync) begin
        cyc  <= '0;
        half <= 1'b0;
        slot <= '0;
      end else if (tick) begin
        if (cyc == CYC_LAST) begin
          cyc  <= '0;
          half <= !half;
          if (half) slot <= load_slot;
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end

  // R8: without a tick or resync the position is frozen
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !resync) |=> ($stable(slot) && $stable(half)));

  // R1: slot index only steps forward by one or wraps to plane 0
  a_r1_slot_forward: assert property (@(posedge clk) disable iff (rst)
    $changed(slot) |-> ((slot == $past(slot) + 1'b1) || (slot == '0)));

  // R6: a sync edge in slave mode restarts at plane 0, first half
  a_r6_resync_restart: assert property (@(posedge clk) disable iff (rst)
    resync |=> ((slot == '0) && !half));
endmodule

// File: rtl/lcdmux_enc.sv
// Level-code encoder, one registered code per plane.
module lcdmux_enc
  import lcdmux_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_FP = 32,
  parameter int SLOT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SLOT_W-1:0]   slot,
  input  logic                half,
  input  logic [NUM_FP-1:0]   blk,
  output logic [2*NUM_BP-1:0] bp_next,
  output logic [2*NUM_BP-1:0] bp_lvl,
  output logic [2*NUM_FP-1:0] fp_lvl
);
  logic [2*NUM_FP-1:0] fp_next;
  logic [NUM_BP-1:0]   bp_active;
  logic [NUM_FP-1:0]   fp_lsb;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    always_comb begin
      if (rst)                       bp_next[2*i +: 2] = (i == 0) ? LVL_FULL : LVL_ONE_THIRD;
      else if (slot == SLOT_W'(i))   bp_next[2*i +: 2] = half ? LVL_GND : LVL_FULL;
      else                           bp_next[2*i +: 2] = half ? LVL_TWO_THIRD : LVL_ONE_THIRD;
    end
    assign bp_active[i] = (bp_lvl[2*i+1] == bp_lvl[2*i]);
  end

  for (genvar j = 0; j < NUM_FP; j++) begin : g_fp
    always_comb begin
      if (rst)         fp_next[2*j +: 2] = LVL_TWO_THIRD;
      else if (blk[j]) fp_next[2*j +: 2] = half ? LVL_FULL : LVL_GND;
      else             fp_next[2*j +: 2] = half ? LVL_ONE_THIRD : LVL_TWO_THIRD;
    end
    assign fp_lsb[j] = fp_lvl[2*j];
  end

  always_ff @(posedge clk) begin
    bp_lvl <= bp_next;
    fp_lvl <= fp_next;
  end

  // R2: exactly one backplane carries an active (00/11) code
  a_r2_one_active: assert property (@(posedge clk) disable iff (rst)
    $countones(bp_active) == 1);

  // R3: every frontplane sits in the opposite half-phase to the backplanes
  a_r3_fp_phase: assert property (@(posedge clk) disable iff (rst)
    fp_lsb == {NUM_FP{~bp_lvl[0]}});
endmodule

// File: rtl/lcdmux_hc.sv
// High-current window timer, counted in oscillator ticks.
module lcdmux_hc #(
  parameter int BP_BITS  = 8,
  parameter int HC_TICKS = 4,
  parameter int HC_W     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [BP_BITS-1:0] bp_next,
  input  logic [BP_BITS-1:0] bp_cur,
  output logic               hc_strobe
);
  logic [HC_W-1:0] hc_cnt;
  logic            load;

  assign load      = (bp_next != bp_cur);
  assign hc_strobe = |hc_cnt;

  always_ff @(posedge clk) begin
    if (rst)                       hc_cnt <= '0;
    else if (load)                 hc_cnt <= HC_W'(HC_TICKS);
    else if (tick && hc_cnt != '0) hc_cnt <= hc_cnt - 1'b1;
  end

  // R7: a backplane change is always accompanied by the strobe
  a_r7_strobe_on_change: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bp_cur) && !$past(rst)) |-> hc_strobe);

  // R7: the window closes only on an oscillator tick
  a_r7_drop_on_tick: assert property (@(posedge clk) disable iff (rst)
    ($fell(hc_strobe) && !$past(rst)) |-> $past(tick));
endmodule

// File: rtl/lcdmux_timing.sv
module lcdmux_timing
  import lcdmux_pkg::*;
#(
  parameter int NUM_BP     = 4,
  parameter int NUM_FP     = 32,
  parameter int HALF_TICKS = 125,
  parameter int HC_TICKS   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       osc_tick,
  input  logic                       master_sel,
  input  logic                       fsync_in,
  input  logic [NUM_BP*NUM_FP-1:0]   disp_word,
  output logic                       fsync_out,
  output logic [2*NUM_BP-1:0]        bp_lvl,
  output logic [2*NUM_FP-1:0]        fp_lvl,
  output logic                       hc_strobe
);
  localparam int SLOT_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;
  localparam int CYC_W  = $clog2(HALF_TICKS + 1);
  localparam int HC_W   = $clog2(HC_TICKS + 1);

  logic [SLOT_W-1:0]   slot;
  logic                half;
  logic                slot_load;
  logic [SLOT_W-1:0]   load_slot;
  logic                resync;
  logic                frame_mark;
  logic [NUM_FP-1:0]   blk;
  logic [2*NUM_BP-1:0] bp_next;

  lcdmux_seq #(
    .NUM_BP(NUM_BP), .HALF_TICKS(HALF_TICKS), .SLOT_W(SLOT_W), .CYC_W(CYC_W)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(osc_tick), .master_sel(master_sel),
    .fsync_in(fsync_in), .slot(slot), .half(half), .slot_load(slot_load),
    .load_slot(load_slot), .resync(resync), .frame_mark(frame_mark)
  );

  // Block capture only at slot boundaries (and reset / resync).
  always_ff @(posedge clk) begin
    if (slot_load) blk <= disp_word[int'(load_slot)*NUM_FP +: NUM_FP];
  end

  lcdmux_enc #(
    .NUM_BP(NUM_BP), .NUM_FP(NUM_FP), .SLOT_W(SLOT_W)
  ) u_enc (
    .clk(clk), .rst(rst), .slot(slot), .half(half), .blk(blk),
    .bp_next(bp_next), .bp_lvl(bp_lvl), .fp_lvl(fp_lvl)
  );

  lcdmux_hc #(
    .BP_BITS(2*NUM_BP), .HC_TICKS(HC_TICKS), .HC_W(HC_W)
  ) u_hc (
    .clk(clk), .rst(rst), .tick(osc_tick), .bp_next(bp_next),
    .bp_cur(bp_lvl), .hc_strobe(hc_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) fsync_out <= 1'b0;
    else     fsync_out <= master_sel && frame_mark;
  end

  // R5: the sync pulse coincides with plane 0 active, first half
  a_r5_sync_with_plane0: assert property (@(posedge clk) disable iff (rst)
    fsync_out |-> (bp_lvl[1:0] == LVL_FULL));

  // R6: a slave never drives the sync output
  a_r6_slave_quiet: assert property (@(posedge clk) disable iff (rst)
    (!master_sel && !$past(master_sel)) |-> !fsync_out);
endmodule

// File: tb/test_lcdmux_timing.sv
module test_lcdmux_timing;
  localparam int NBP   = 4;
  localparam int NFP   = 32;
  localparam int HALF  = 125;
  localparam int HC    = 4;
  localparam int SLOT  = 2 * HALF;
  localparam int FRAME = NBP * SLOT;
  localparam int W     = NBP * NFP;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst = 1'b1;
  logic           tick = 1'b0;
  logic           master = 1'b1;
  logic           fsin = 1'b0;
  logic [W-1:0]   data = '0;
  logic           fsync_out;
  logic [2*NBP-1:0] bp_lvl;
  logic [2*NFP-1:0] fp_lvl;
  logic           hc_strobe;

  lcdmux_timing #(.NUM_BP(NBP), .NUM_FP(NFP), .HALF_TICKS(HALF), .HC_TICKS(HC)) i_lcdmux_timing (
    .clk(clk), .rst(rst), .osc_tick(tick), .master_sel(master), .fsync_in(fsin),
    .disp_word(data), .fsync_out(fsync_out), .bp_lvl(bp_lvl), .fp_lvl(fp_lvl),
    .hc_strobe(hc_strobe)
  );

  int checks = 0;
  int fails  = 0;
  string phase = "R9";

  typedef struct {
    logic [2*NBP-1:0] bp;
    logic [2*NFP-1:0] fp;
    logic             fs;
    string            tag;
  } exp_t;
  exp_t q[$];

  // Tick generator: tdiv 0 = no ticks, N = one tick every N clocks
  int tdiv = 1;
  int tcnt = 0;
  always @(posedge clk) begin
    #1;
    tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    tick = (tdiv > 0) && (tcnt == 0);
  end

  function automatic logic [2*NBP-1:0] bp_code(int s, int h);
    logic [2*NBP-1:0] v;
    for (int i = 0; i < NBP; i++)
      v[2*i +: 2] = (i == s) ? ((h != 0) ? 2'b00 : 2'b11) : ((h != 0) ? 2'b10 : 2'b01);
    return v;
  endfunction

  function automatic logic [2*NFP-1:0] fp_code(logic [NFP-1:0] b, int h);
    logic [2*NFP-1:0] v;
    for (int j = 0; j < NFP; j++)
      v[2*j +: 2] = b[j] ? ((h != 0) ? 2'b11 : 2'b00) : ((h != 0) ? 2'b01 : 2'b10);
    return v;
  endfunction

  // Driver side of the scoreboard: tick-position model pushes expectations.
  int             pos = 0;
  logic [NFP-1:0] mblk = '0;
  logic           mprev = 1'b0;
  logic           mfs1 = 1'b0;
  always @(posedge clk) begin : model
    exp_t e;
    logic rise;
    if (rst) begin
      e.bp = bp_code(0, 0); e.fp = {NFP{2'b10}}; e.fs = 1'b0; e.tag = "R9";
    end else begin
      e.bp = bp_code(pos / SLOT, (pos % SLOT) / HALF);
      e.fp = fp_code(mblk, (pos % SLOT) / HALF);
      e.fs = master && mfs1;
      e.tag = phase;
    end
    q.push_back(e);
    rise  = !rst && !master && fsin && !mprev;
    mfs1  = !rst && tick && (pos == FRAME - 1) && !rise;
    mprev = rst ? 1'b0 : fsin;
    if (rst || rise) begin
      pos = 0; mblk = data[NFP-1:0];
    end else if (tick) begin
      pos = (pos + 1) % FRAME;
      if (pos % SLOT == 0) mblk = data[(pos / SLOT) * NFP +: NFP];
    end
  end

  // Monitor side: pop and compare, plus frame-length and strobe-window checks.
  int   ncyc = 0;
  int   last_fs = -1;
  logic hc_prev = 1'b0;
  logic hc_ok = 1'b0;
  int   hc_ticks = 0;
  int   hc_runs = 0;
  logic per_clock = 1'b1;
  always @(negedge clk) begin : monitor
    exp_t e;
    ncyc++;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (bp_lvl !== e.bp) begin
        fails++;
        $display("FAIL %s/R2 bp_lvl actual %h expected %h", e.tag, bp_lvl, e.bp);
      end
      checks++;
      if (fp_lvl !== e.fp) begin
        fails++;
        $display("FAIL %s/R3 fp_lvl actual %h expected %h", e.tag, fp_lvl, e.fp);
      end
      checks++;
      if (fsync_out !== e.fs) begin
        fails++;
        $display("FAIL %s/R5 fsync_out actual %b expected %b", e.tag, fsync_out, e.fs);
      end
    end
    // R1: frame length in clocks with one tick per clock
    if (fsync_out === 1'b1 && !rst) begin
      if (per_clock && last_fs >= 0) begin
        checks++;
        if (ncyc - last_fs != FRAME) begin
          fails++;
          $display("FAIL R1 sync spacing actual %0d expected %0d", ncyc - last_fs, FRAME);
        end
      end
      last_fs = ncyc;
    end
    // R7: each strobe window spans exactly HC ticks
    if (hc_strobe === 1'b1) begin
      if (!hc_prev) begin hc_ok = master; hc_ticks = 0; end
      if (rst || !master) hc_ok = 1'b0;
      hc_ticks += tick ? 1 : 0;
    end else if (hc_prev) begin
      if (hc_ok && !rst) begin
        checks++;
        hc_runs++;
        if (hc_ticks != HC) begin
          fails++;
          $display("FAIL R7 strobe ticks actual %0d expected %0d", hc_ticks, HC);
        end
      end
    end
    hc_prev = hc_strobe;
  end

  int unsigned seed = 32'h1234_5678;
  task automatic new_data();
    for (int k = 0; k < NBP; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      data[k*NFP +: NFP] = seed ^ {seed[15:0], seed[31:16]};
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
    $finish;
  end

  initial begin : driver
    // R9: reset state, then basic master operation
    data = {32'hF0F0_0001, 32'h8000_0003, 32'h0F0F_5555, 32'hA5A5_C3C3};
    step(5);
    rst = 1'b0;
    phase = "R2";
    step(2100);
    // R4: pattern churn in mid-slot
    phase = "R4";
    for (int k = 0; k < 60; k++) begin
      new_data();
      step(37);
    end
    // R8: slow ticks, then a long stall
    phase = "R8";
    per_clock = 1'b0;
    tdiv = 3;
    step(3300);
    tdiv = 0;
    step(300);
    tdiv = 1;
    step(500);
    // R6: slave mode with realignment edges
    phase = "R6";
    master = 1'b0;
    step(700);
    fsin = 1'b1; step(1); fsin = 1'b0;
    step(613);
    fsin = 1'b1; step(50); fsin = 1'b0;
    step(420);
    new_data();
    fsin = 1'b1; step(1); fsin = 1'b0;
    step(900);
    // R6: master ignores the sync input
    master = 1'b1;
    per_clock = 1'b1;
    last_fs = -1;
    for (int k = 0; k < 180; k++) begin
      fsin = ~fsin;
      step(7);
    end
    fsin = 1'b0;
    // R9: reset in mid-frame
    phase = "R9";
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    last_fs = -1;
    phase = "R2";
    step(2200);
    // R7: make sure strobe windows were observed
    checks++;
    if (hc_runs < 20) begin
      fails++;
      $display("FAIL R7 strobe windows actual %0d expected >= 20", hc_runs);
    end
    step(4);
    summary();
    $finish;
  end
endmodule